// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple single-beat host port and one SDR SDRAM device with a 64-bit data path and four banks. After reset it runs the device start-up: a long quiet period with the clock enable low, a precharge of all banks, two refreshes and a mode-register load. It then serves host reads and writes one at a time. Each access opens the addressed row, issues one READ or WRITE, and closes the row again with a PRECHARGE. Read data is sampled a programmed number of cycles after the READ and returned on a response strobe.

Every minimum spacing between commands is held by its own small down-counter, counted in clock cycles for a 10 ns clock. A free-running timer raises a refresh request at a fixed interval. That request is served at the first idle slot, ahead of any waiting host request.

Top module: `sdram_seq`

## Requirements
- R1: Command pins {cs_n,ras_n,cas_n,we_n} use NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, MODE LOAD=0000. Out of reset the block holds NOP with sd_cke low for INIT_CYC cycles. It then issues exactly PRECHARGE with A10=1, REFRESH, REFRESH, MODE LOAD, in that order, before any other command.
- R2: The mode word on sd_a has bits [2:0]=000 (one-beat bursts), bit 3=0 and bits [6:4]=CAS_LAT.
- R3: At least T_MRD=2 cycles separate MODE LOAD from the next command.
- R4: At least T_RCD=3 cycles separate ACTIVE from READ or WRITE.
- R5: At least T_RAS=5 cycles separate ACTIVE from PRECHARGE.
- R6: At least T_RC=8 cycles separate ACTIVE from the next ACTIVE, and REFRESH from the next ACTIVE or REFRESH.
- R7: At least T_RP=3 cycles separate PRECHARGE from the next ACTIVE or REFRESH.
- R8: At least T_WR=2 cycles separate WRITE from PRECHARGE.
- R9: On the WRITE cycle the block drives the write data with sd_dq_oe high and sd_dqm equal to the inverted byte enables. Bytes whose enable is low keep their old value in memory.
- R10: Read data is sampled from sd_dq_i exactly CAS_LAT cycles after the READ. It appears on rsp_rdata with rsp_valid high in the following cycle, in request order.
- R11: A refresh request arises every REF_INT cycles. When it is pending it is issued at the next idle slot, before any host request, so consecutive refreshes are never more than REF_INT+20 cycles apart.
- R12: req_addr is {bank, row, column}. An accepted request produces ACTIVE with that bank and row in the next cycle. Every READ or WRITE targets a bank whose row was opened by ACTIVE and not yet precharged, with the column on sd_a low bits and A10=0.
- R13: req_ready stays low until start-up is complete and while any command spacing still blocks an ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Row, column or mode word |
| sd_dqm | output | 8 | Byte mask |
| sd_dq_o | output | 64 | Data toward device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_i | input | 64 | Data from device |

## Verification
Full-word writes followed by reads of the same address show the basic data path and the read-capture cycle. Partial byte-enable writes over known data show whether masking is applied on the WRITE cycle. Accesses spread over different banks and rows of one bank show address mapping and aliasing. A long stream of mixed back-to-back requests exposes every command gap and shows that refresh still wins slots under load. An idle stretch checks that refreshes keep coming when there is no traffic.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int DATA_W   = 64,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int CAS_LAT  = 3,
  parameter int T_RCD    = 3,
  parameter int T_RP     = 3,
  parameter int T_RAS    = 5,
  parameter int T_RC     = 8,
  parameter int T_MRD    = 2,
  parameter int T_WR     = 2,
  parameter int REF_INT  = 1560,
  parameter int INIT_CYC = 20000,
  localparam int BE_W    = DATA_W / 8,
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_i
);

  localparam int CNT_W = $clog2(T_RC + T_RAS + T_RCD + T_RP + T_MRD + T_WR + 2);
  localparam int PWR_W = $clog2(INIT_CYC + 1);
  localparam int REF_W = $clog2(REF_INT + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((CAS_LAT & 7) << 4);
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);

  typedef enum logic [2:0] {S_PWR, S_IPRE, S_IREF, S_IMRS, S_IDLE, S_RW, S_PRE} st_t;

  st_t               st;
  logic [3:0]        cmd_q;
  logic [PWR_W-1:0]  pwr_cnt;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_due, iref;
  logic [CNT_W-1:0]  rcd_c, rp_c, ras_c, rc_c, mrd_c, wr_c;
  logic              op_we;
  logic [COL_W-1:0]  op_col;
  logic [DATA_W-1:0] op_wdata;
  logic [BE_W-1:0]   op_be;
  logic [CAS_LAT-1:0] rd_sh;
  logic              go;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign go        = (mrd_c == '0) && (rp_c == '0) && (rc_c == '0);
  assign req_ready = (st == S_IDLE) && go && !ref_due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PWR;
      cmd_q    <= C_NOP;
      pwr_cnt  <= PWR_W'(INIT_CYC - 1);
      ref_cnt  <= REF_W'(REF_INT - 1);
      ref_due  <= 1'b0;
      iref     <= 1'b0;
      sd_cke   <= 1'b0;
      sd_ba    <= '0;
      sd_a     <= '0;
      sd_dqm   <= '0;
      sd_dq_o  <= '0;
      sd_dq_oe <= 1'b0;
      rcd_c    <= '0;
      rp_c     <= '0;
      ras_c    <= '0;
      rc_c     <= '0;
      mrd_c    <= '0;
      wr_c     <= '0;
      op_we    <= 1'b0;
      op_col   <= '0;
      op_wdata <= '0;
      op_be    <= '0;
    end else begin
      cmd_q    <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      if (rcd_c != '0) rcd_c <= rcd_c - 1'b1;
      if (rp_c  != '0) rp_c  <= rp_c  - 1'b1;
      if (ras_c != '0) ras_c <= ras_c - 1'b1;
      if (rc_c  != '0) rc_c  <= rc_c  - 1'b1;
      if (mrd_c != '0) mrd_c <= mrd_c - 1'b1;
      if (wr_c  != '0) wr_c  <= wr_c  - 1'b1;

      case (st)
        S_PWR: begin
          if (pwr_cnt == '0) begin
            sd_cke <= 1'b1;
            st     <= S_IPRE;
          end else begin
            pwr_cnt <= pwr_cnt - 1'b1;
          end
        end
        S_IPRE: begin
          cmd_q <= C_PRE;
          sd_a  <= ALL_BANKS;
          rp_c  <= CNT_W'(T_RP - 1);
          st    <= S_IREF;
        end
        S_IREF: begin
          if (rp_c == '0 && rc_c == '0) begin
            cmd_q <= C_REF;
            rc_c  <= CNT_W'(T_RC - 1);
            iref  <= 1'b1;
            if (iref) st <= S_IMRS;
          end
        end
        S_IMRS: begin
          if (rc_c == '0) begin
            cmd_q <= C_MRS;
            sd_a  <= MODE_WORD;
            mrd_c <= CNT_W'(T_MRD - 1);
            st    <= S_IDLE;
          end
        end
        S_IDLE: begin
          if (go && ref_due) begin
            cmd_q   <= C_REF;
            rc_c    <= CNT_W'(T_RC - 1);
            ref_due <= 1'b0;
          end else if (req_ready && req_valid) begin
            cmd_q    <= C_ACT;
            sd_ba    <= req_addr[ADDR_W-1 -: BANK_W];
            sd_a     <= req_addr[COL_W +: ROW_W];
            op_we    <= req_we;
            op_col   <= req_addr[COL_W-1:0];
            op_wdata <= req_wdata;
            op_be    <= req_be;
            rcd_c    <= CNT_W'(T_RCD - 1);
            ras_c    <= CNT_W'(T_RAS - 1);
            rc_c     <= CNT_W'(T_RC - 1);
            st       <= S_RW;
          end
        end
        S_RW: begin
          if (rcd_c == '0) begin
            sd_a <= ROW_W'(op_col);
            if (op_we) begin
              cmd_q    <= C_WR;
              sd_dq_o  <= op_wdata;
              sd_dq_oe <= 1'b1;
              sd_dqm   <= ~op_be;
              wr_c     <= CNT_W'(T_WR - 1);
            end else begin
              cmd_q <= C_RD;
            end
            st <= S_PRE;
          end
        end
        S_PRE: begin
          if (ras_c == '0 && wr_c == '0) begin
            cmd_q <= C_PRE;
            sd_a  <= '0;
            rp_c  <= CNT_W'(T_RP - 1);
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (ref_cnt == '0) begin
        ref_cnt <= REF_W'(REF_INT - 1);
        ref_due <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
    end
  end

  generate
    if (CAS_LAT > 1) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_sh <= '0;
        else        rd_sh <= {rd_sh[CAS_LAT-2:0], cmd_q == C_RD};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_sh <= '0;
        else        rd_sh <= cmd_q == C_RD;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_sh[CAS_LAT-1];
      if (rd_sh[CAS_LAT-1]) rsp_rdata <= sd_dq_i;
    end
  end

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int CAS_LAT = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       dq_oe
);

  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_ACT = 4'b0011;
  localparam logic [3:0] K_RD  = 4'b0101;
  localparam logic [3:0] K_WR  = 4'b0100;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_MRS = 4'b0000;

  p_mrd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == K_MRS |=> cmd == K_NOP);

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RD || cmd == K_WR) |-> ($past(cmd) != K_ACT && $past(cmd, 2) != K_ACT));

  p_wr_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == K_PRE |-> $past(cmd) != K_WR);

  p_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> cmd == K_WR);

  p_rsp_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd, CAS_LAT + 1) == K_RD);

  p_accept_act_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd == K_ACT);

  p_ready_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cmd == K_NOP);

endmodule

bind sdram_seq sdram_seq_chk #(.CAS_LAT(CAS_LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .dq_oe    (sd_dq_oe)
);

// File: tb/sdram_seq_tb.sv
module sdram_seq_tb;
  localparam int CL      = 3;
  localparam int REF_INT = 1560;

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                         K_MRS = 4'b0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [7:0]  sd_dqm;
  logic [63:0] sd_dq_o;
  logic [63:0] sd_dq_i = '1;

  always #4 clk = ~clk;

  sdram_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o),
    .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  function automatic void check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural device and protocol monitor
  logic [63:0] dev   [logic [21:0]];
  logic [63:0] shadow[logic [21:0]];
  logic [11:0] open_row [4];
  bit          is_open  [4];
  typedef struct { int due; logic [63:0] d; } rdq_t;
  rdq_t        rdq[$];
  logic [63:0] expq[$];
  int last_act = -1000, last_pre = -1000, last_ref = -1000, last_mrs = -1000, last_wr = -1000;
  int ncmd = 0, nref = 0, nrsp = 0;
  bit mrs_seen = 0, early_ready = 0;
  logic [3:0] init_exp [4] = '{K_PRE, K_REF, K_REF, K_MRS};

  always @(negedge clk) begin
    logic [3:0]  c;
    logic [21:0] k;
    logic [63:0] m;
    if (rdq.size() != 0 && rdq[0].due == cyc) begin
      sd_dq_i = rdq[0].d;
      void'(rdq.pop_front());
    end else begin
      sd_dq_i = 64'hBAD0_BAD1_BAD2_BAD3;
    end
    if (rst_n) begin
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!mrs_seen && req_ready) early_ready = 1;
      if (rsp_valid) begin
        nrsp++;
        if (expq.size() != 0) check(rsp_rdata == expq.pop_front(), "R10 read data", rsp_rdata, 64'h0);
        else check(0, "R10 unexpected response", rsp_rdata, 64'h0);
      end
      if (c != K_NOP) begin
        if (ncmd < 4) begin
          check(c == init_exp[ncmd], "R1 init order", 64'(c), 64'(init_exp[ncmd]));
          check(sd_cke, "R1 cke high", 64'(sd_cke), 64'd1);
        end
        ncmd++;
        check(cyc - last_mrs >= 2, "R3 mode gap", 64'(cyc - last_mrs), 64'd2);
        case (c)
          K_MRS: begin
            check(sd_a[6:4] == 3'(CL) && sd_a[3:0] == 4'd0, "R2 mode word", 64'(sd_a), 64'(CL << 4));
            last_mrs = cyc; mrs_seen = 1;
          end
          K_ACT: begin
            check(cyc - last_pre >= 3, "R7 pre->act", 64'(cyc - last_pre), 64'd3);
            check(cyc - last_ref >= 8, "R6 ref->act", 64'(cyc - last_ref), 64'd8);
            check(cyc - last_act >= 8, "R6 act->act", 64'(cyc - last_act), 64'd8);
            open_row[sd_ba] = sd_a; is_open[sd_ba] = 1; last_act = cyc;
          end
          K_RD, K_WR: begin
            check(is_open[sd_ba], "R12 row open", 64'(is_open[sd_ba]), 64'd1);
            check(sd_a[10] == 1'b0, "R12 A10 low", 64'(sd_a), 64'h0);
            check(cyc - last_act >= 3, "R4 act->rw", 64'(cyc - last_act), 64'd3);
            k = {sd_ba, open_row[sd_ba], sd_a[7:0]};
            m = dev.exists(k) ? dev[k] : 64'h0;
            if (c == K_WR) begin
              check(sd_dq_oe, "R9 data driven", 64'(sd_dq_oe), 64'd1);
              for (int b = 0; b < 8; b++)
                if (!sd_dqm[b]) m[b*8 +: 8] = sd_dq_o[b*8 +: 8];
              dev[k] = m; last_wr = cyc;
            end else begin
              rdq.push_back('{due: cyc + CL, d: m});
            end
          end
          K_PRE: begin
            check(cyc - last_act >= 5, "R5 act->pre", 64'(cyc - last_act), 64'd5);
            check(cyc - last_wr >= 2, "R8 wr->pre", 64'(cyc - last_wr), 64'd2);
            if (sd_a[10]) for (int b = 0; b < 4; b++) is_open[b] = 0;
            else is_open[sd_ba] = 0;
            last_pre = cyc;
          end
          K_REF: begin
            check(cyc - last_pre >= 3, "R7 pre->ref", 64'(cyc - last_pre), 64'd3);
            check(cyc - last_ref >= 8, "R6 ref->ref", 64'(cyc - last_ref), 64'd8);
            if (nref >= 2)
              check(cyc - last_ref <= REF_INT + 20, "R11 refresh interval", 64'(cyc - last_ref), 64'(REF_INT + 20));
            nref++; last_ref = cyc;
          end
          default: check(0, "R1 illegal command", 64'(c), 64'(K_NOP));
        endcase
      end else begin
        check(!sd_dq_oe, "R9 oe only on write", 64'(sd_dq_oe), 64'd0);
      end
    end
  end

  int n_reads = 0;

  task automatic xfer(input bit we, input logic [21:0] ad, input logic [63:0] d, input logic [7:0] be);
    logic [63:0] old, msk;
    req_valid = 1; req_we = we; req_addr = ad; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    old = shadow.exists(ad) ? shadow[ad] : 64'h0;
    if (we) begin
      for (int b = 0; b < 8; b++) msk[b*8 +: 8] = {8{be[b]}};
      shadow[ad] = (old & ~msk) | (d & msk);
    end else begin
      expq.push_back(old);
      n_reads++;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    int ref_before;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_NOP, "R1 reset NOP",
          64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(K_NOP));
    check(!sd_cke, "R1 cke low in wait", 64'(sd_cke), 64'd0);
    check(!req_ready, "R13 not ready at start", 64'(req_ready), 64'd0);
    check(!rsp_valid, "R10 no response at reset", 64'(rsp_valid), 64'd0);
    while (!mrs_seen) @(negedge clk);
    check(cyc >= 20000, "R1 init wait length", 64'(cyc), 64'd20000);

    xfer(1, {2'd0, 12'h001, 8'h10}, 64'h0123_4567_89AB_CDEF, 8'hFF);
    xfer(0, {2'd0, 12'h001, 8'h10}, '0, '0);
    xfer(1, {2'd0, 12'h001, 8'h10}, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
    xfer(0, {2'd0, 12'h001, 8'h10}, '0, '0);
    xfer(1, {2'd0, 12'h002, 8'h10}, 64'hAAAA_5555_AAAA_5555, 8'hFF);
    xfer(1, {2'd3, 12'h001, 8'h10}, 64'h1111_2222_3333_4444, 8'hFF);
    xfer(0, {2'd0, 12'h001, 8'h10}, '0, '0);
    xfer(0, {2'd0, 12'h002, 8'h10}, '0, '0);
    xfer(0, {2'd3, 12'h001, 8'h10}, '0, '0);
    xfer(0, {2'd2, 12'h7FF, 8'hFF}, '0, '0);

    for (int i = 0; i < 400; i++) begin
      logic [21:0] ad;
      ad = {2'($urandom), 12'($urandom % 4), 8'($urandom % 8)};
      xfer(1'($urandom), ad, {$urandom, $urandom}, 8'($urandom));
    end

    ref_before = nref;
    repeat (5000) @(negedge clk);
    check(nref - ref_before >= 3, "R11 idle refresh count", 64'(nref - ref_before), 64'd3);
    check(expq.size() == 0 && nrsp == n_reads, "R10 all reads answered", 64'(nrsp), 64'(n_reads));
    check(!early_ready, "R13 ready before start-up done", 64'(early_ready), 64'd0);
    finish_run();
  end
endmodule